// File: doc/BRIEF.md
# Wireless core power-up sequencer

This block wakes an on-chip wireless subsystem after a one-cycle start pulse. It first turns on the subsystem's interconnect clock and gives it ten milliseconds to settle. Next it holds the bus-side shim reset and the shim core reset for one more millisecond, then releases both. Last, it programs the shim's misc control and MAC control registers through a single-beat write master. The order of those writes is fixed. Clocks are forced on and the macro is held in soft reset. The MAC clocks are enabled with gating forced. The overrides are then removed one at a time, and only the MAC clock enable is left set.

All waits count clock cycles. A parameter gives the number of cycles per millisecond, so simulation can use a small value. The block keeps its own copy of each control register. Every clearing step is therefore a full-register write with one bit removed. The block reports busy while a sequence runs and done once it has finished.

Top module: `wlan_pwrup_seq`

## Requirements
- R1: After synchronous reset, `ocp_clk_en_o`, `wr_en_o`, `busy_o` and `done_o` are low, and `shim_bus_rst_o` and `shim_rst_o` are high (asserted).
- R2: A start pulse sampled while idle or done raises `ocp_clk_en_o` and `busy_o` from the next cycle on. The resets stay asserted for 10 × CYCLES_PER_MS cycles of clock settling.
- R3: After the settling wait, both reset outputs stay high for another CYCLES_PER_MS cycles, then fall in the same cycle.
- R4: In the cycle after the resets fall, the block writes 0x5 to address BASE_ADDR+0x00 (misc control). Bit 2 is force-clocks-on and bit 0 is soft reset.
- R5: A write holds `wr_en_o`, `wr_addr_o` and `wr_data_o` steady until `wr_ready_i` is sampled high. The next step begins in the cycle after that handshake.
- R6: After the first write completes, no write is issued for CYCLES_PER_MS cycles. Then 0x3 is written to BASE_ADDR+0x10 (MAC control), where bit 1 is force gated clock and bit 0 is clock enable.
- R7: The remaining writes follow one after another in this order: misc 0x4 (soft reset cleared), misc 0x0 (force-clocks-on cleared), then MAC 0x1 (force gated clock cleared). Bits 31:3 of every write are zero, so the MAC core-reset bit 16 and the core bits 13:2 are never set.
- R8: When the last write completes, `done_o` rises and `busy_o` falls. `done_o` stays high until the next accepted start. Meanwhile the clock enable stays high and both resets stay low.
- R9: A start pulse received while `busy_o` is high has no effect on timing or outputs.
- R10: A synchronous reset in the middle of a sequence returns every output to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| ocp_clk_en_o | output | 1 | Subsystem interconnect clock enable |
| shim_bus_rst_o | output | 1 | Bus-side shim reset, active high |
| shim_rst_o | output | 1 | Shim core reset, active high |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_en_o | output | 1 | Write request strobe |
| wr_ready_i | input | 1 | Target accepts the write when high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
Two cases are hard to reach from the ports. One is a write that stalls while the next write is already queued behind it. The other is a start pulse that lands in the middle of a timed wait. The bench drives the ready input in three modes: always high, randomly high, and rarely high. Long stalls therefore occur on each of the five writes, including the back-to-back group. Start pulses are injected during the settling wait, the reset hold and the write phase. A behavioural model counts cycles from the accepted start and is compared with every output on every cycle. A reset is also forced halfway through the settling wait.

// File: rtl/wlan_pwrup_pkg.sv
package wlan_pwrup_pkg;

    // Register offsets inside the shim window
    localparam int MISC_OFS = 'h00;
    localparam int MAC_OFS  = 'h10;

    // Misc control bit positions
    localparam int MISC_FORCE_CLK_BIT = 2;
    localparam int MISC_SOFT_RST_BIT  = 0;

    // MAC control bit positions
    localparam int MAC_FGC_BIT    = 1;
    localparam int MAC_CLK_EN_BIT = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_WAIT,
        ST_RST_HOLD,
        ST_WR_MISC_ON,
        ST_SR_WAIT,
        ST_WR_MAC_ON,
        ST_WR_SR_OFF,
        ST_WR_FC_OFF,
        ST_WR_FGC_OFF,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_wr_master.sv
module pwrup_wr_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wr_ready_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              ack_o
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_reg_t;

    wr_reg_t wr_d, wr_q;

    assign ack_o = wr_q.req && wr_ready_i;

    always_comb begin
        wr_d = wr_q;
        if (issue_i) begin
            wr_d.req  = 1'b1;
            wr_d.addr = addr_i;
            wr_d.data = data_i;
        end else if (ack_o) begin
            wr_d.req  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_en_o   = wr_q.req;
    assign wr_addr_o = wr_q.addr;
    assign wr_data_o = wr_q.data;

endmodule

// File: rtl/wlan_pwrup_seq.sv
module wlan_pwrup_seq
    import wlan_pwrup_pkg::*;
#(
    parameter int              ADDR_W        = 32,
    parameter int              DATA_W        = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
    parameter int              CYCLES_PER_MS = 250000,
    parameter int              SETTLE_MS     = 10,
    parameter int              HOLD_MS       = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              ocp_clk_en_o,
    output logic              shim_bus_rst_o,
    output logic              shim_rst_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_en_o,
    input  logic              wr_ready_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SETTLE_CYC = SETTLE_MS * CYCLES_PER_MS;
    localparam int HOLD_CYC   = HOLD_MS * CYCLES_PER_MS;
    localparam int MAX_CYC    = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CNT_W      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] SETTLE_LEN = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LEN   = CNT_W'(HOLD_CYC - 1);
    localparam logic [ADDR_W-1:0] MISC_ADDR = BASE_ADDR + ADDR_W'(MISC_OFS);
    localparam logic [ADDR_W-1:0] MAC_ADDR  = BASE_ADDR + ADDR_W'(MAC_OFS);

    typedef struct packed {
        seq_state_e        state;
        logic              clk_en;
        logic              bus_rst;
        logic              core_rst;
        logic              done;
        logic [DATA_W-1:0] misc;
        logic [DATA_W-1:0] mac;
    } seq_reg_t;

    seq_reg_t          seq_d, seq_q;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0]  tmr_len;
    logic              wr_issue, wr_ack;
    logic [ADDR_W-1:0] wr_addr_n;
    logic [DATA_W-1:0] wr_data_n;

    pwrup_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .dec_i  (tmr_dec),
        .zero_o (tmr_zero)
    );

    pwrup_wr_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (wr_issue),
        .addr_i     (wr_addr_n),
        .data_i     (wr_data_n),
        .wr_ready_i (wr_ready_i),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .ack_o      (wr_ack)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        tmr_dec   = 1'b0;
        wr_issue  = 1'b0;
        wr_addr_n = MISC_ADDR;
        wr_data_n = '0;
        unique case (seq_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    seq_d.state    = ST_CLK_WAIT;
                    seq_d.clk_en   = 1'b1;
                    seq_d.bus_rst  = 1'b1;
                    seq_d.core_rst = 1'b1;
                    seq_d.done     = 1'b0;
                    seq_d.misc     = '0;
                    seq_d.mac      = '0;
                    tmr_load       = 1'b1;
                    tmr_len        = SETTLE_LEN;
                end
            end
            ST_CLK_WAIT: begin
                if (tmr_zero) begin
                    seq_d.state = ST_RST_HOLD;
                    tmr_load    = 1'b1;
                    tmr_len     = HOLD_LEN;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RST_HOLD: begin
                if (tmr_zero) begin
                    seq_d.state    = ST_WR_MISC_ON;
                    seq_d.bus_rst  = 1'b0;
                    seq_d.core_rst = 1'b0;
                    seq_d.misc[MISC_FORCE_CLK_BIT] = 1'b1;
                    seq_d.misc[MISC_SOFT_RST_BIT]  = 1'b1;
                    wr_issue  = 1'b1;
                    wr_addr_n = MISC_ADDR;
                    wr_data_n = seq_d.misc;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WR_MISC_ON: begin
                if (wr_ack) begin
                    seq_d.state = ST_SR_WAIT;
                    tmr_load    = 1'b1;
                    tmr_len     = HOLD_LEN;
                end
            end
            ST_SR_WAIT: begin
                if (tmr_zero) begin
                    seq_d.state = ST_WR_MAC_ON;
                    seq_d.mac[MAC_FGC_BIT]    = 1'b1;
                    seq_d.mac[MAC_CLK_EN_BIT] = 1'b1;
                    wr_issue  = 1'b1;
                    wr_addr_n = MAC_ADDR;
                    wr_data_n = seq_d.mac;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WR_MAC_ON: begin
                if (wr_ack) begin
                    seq_d.state = ST_WR_SR_OFF;
                    seq_d.misc[MISC_SOFT_RST_BIT] = 1'b0;
                    wr_issue  = 1'b1;
                    wr_addr_n = MISC_ADDR;
                    wr_data_n = seq_d.misc;
                end
            end
            ST_WR_SR_OFF: begin
                if (wr_ack) begin
                    seq_d.state = ST_WR_FC_OFF;
                    seq_d.misc[MISC_FORCE_CLK_BIT] = 1'b0;
                    wr_issue  = 1'b1;
                    wr_addr_n = MISC_ADDR;
                    wr_data_n = seq_d.misc;
                end
            end
            ST_WR_FC_OFF: begin
                if (wr_ack) begin
                    seq_d.state = ST_WR_FGC_OFF;
                    seq_d.mac[MAC_FGC_BIT] = 1'b0;
                    wr_issue  = 1'b1;
                    wr_addr_n = MAC_ADDR;
                    wr_data_n = seq_d.mac;
                end
            end
            ST_WR_FGC_OFF: begin
                if (wr_ack) begin
                    seq_d.state = ST_DONE;
                    seq_d.done  = 1'b1;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state    <= ST_IDLE;
            seq_q.clk_en   <= 1'b0;
            seq_q.bus_rst  <= 1'b1;
            seq_q.core_rst <= 1'b1;
            seq_q.done     <= 1'b0;
            seq_q.misc     <= '0;
            seq_q.mac      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ocp_clk_en_o   = seq_q.clk_en;
    assign shim_bus_rst_o = seq_q.bus_rst;
    assign shim_rst_o     = seq_q.core_rst;
    assign done_o         = seq_q.done;
    assign busy_o         = (seq_q.state != ST_IDLE) && (seq_q.state != ST_DONE);

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        ocp_clk_en_o,
    input logic        shim_bus_rst_o,
    input logic        shim_rst_o,
    input logic [31:0] wr_addr_o,
    input logic [31:0] wr_data_o,
    input logic        wr_en_o,
    input logic        wr_ready_i,
    input logic        busy_o,
    input logic        done_o
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && ocp_clk_en_o));

    // R3
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(shim_rst_o) || $fell(shim_bus_rst_o)) |-> (!shim_rst_o && !shim_bus_rst_o && busy_o));

    // R4
    wr_out_of_rst_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (!shim_rst_o && !shim_bus_rst_o && ocp_clk_en_o));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !wr_ready_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R7
    wr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o[31:3] == 29'd0 && wr_addr_o[3:0] == 4'd0));

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !wr_en_o && ocp_clk_en_o && !shim_rst_o));

endmodule

bind wlan_pwrup_seq pwrup_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .ocp_clk_en_o   (ocp_clk_en_o),
    .shim_bus_rst_o (shim_bus_rst_o),
    .shim_rst_o     (shim_rst_o),
    .wr_addr_o      (wr_addr_o),
    .wr_data_o      (wr_data_o),
    .wr_en_o        (wr_en_o),
    .wr_ready_i     (wr_ready_i),
    .busy_o         (busy_o),
    .done_o         (done_o)
);

// File: tb/tb_wlan_pwrup_seq.sv
module tb_wlan_pwrup_seq;
    localparam int CPM = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ready = 1'b1;
    logic        clk_en, bus_rst, core_rst, wr_en, busy, done;
    logic [31:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ready_mode = 0;
    bit mid_reset = 0;

    // behavioural model: 0 idle, 1 settle, 2 reset hold, 3 writing, 4 gap, 5 done
    int m_state = 0;
    int m_cnt = 0;
    int m_widx = 0;
    int exp_addr[5] = '{32'h0, 32'h10, 32'h0, 32'h0, 32'h10};
    int exp_data[5] = '{32'h5, 32'h3, 32'h4, 32'h0, 32'h1};

    always #2 clk = ~clk;

    wlan_pwrup_seq #(.CYCLES_PER_MS(CPM)) dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .ocp_clk_en_o   (clk_en),
        .shim_bus_rst_o (bus_rst),
        .shim_rst_o     (core_rst),
        .wr_addr_o      (wr_addr),
        .wr_data_o      (wr_data),
        .wr_en_o        (wr_en),
        .wr_ready_i     (ready),
        .busy_o         (busy),
        .done_o         (done)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0;
        end else begin
            case (m_state)
                0, 5: if (start) begin m_state = 1; m_cnt = 10 * CPM; end
                1: begin m_cnt--; if (m_cnt == 0) begin m_state = 2; m_cnt = CPM; end end
                2: begin m_cnt--; if (m_cnt == 0) begin m_state = 3; m_widx = 0; end end
                3: if (ready) begin
                       m_widx++;
                       if (m_widx == 1) begin m_state = 4; m_cnt = CPM; end
                       else if (m_widx == 5) m_state = 5;
                   end
                4: begin m_cnt--; if (m_cnt == 0) m_state = 3; end
                default: m_state = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        case (ready_mode)
            0: ready = 1'b1;
            1: ready = ($urandom_range(0, 1) == 1);
            default: ready = ($urandom_range(0, 5) == 0);
        endcase
        if (!rst) begin
            if (m_state == 0) begin
                chk(mid_reset ? "R10 clk_en" : "R1 clk_en", clk_en, 0);
                chk(mid_reset ? "R10 resets" : "R1 resets", {bus_rst, core_rst}, 2'b11);
                chk(mid_reset ? "R10 wr_en" : "R1 wr_en", wr_en, 0);
                chk(mid_reset ? "R10 busy/done" : "R1 busy/done", {busy, done}, 2'b00);
            end else begin
                chk("R2 clk_en", clk_en, 1);
                chk("R3 bus reset", bus_rst, (m_state == 1 || m_state == 2));
                chk("R3 shim reset", core_rst, (m_state == 1 || m_state == 2));
                chk("R5 wr_en", wr_en, (m_state == 3));
                if (m_state == 3) begin
                    chk(m_widx == 0 ? "R4 addr" : (m_widx == 1 ? "R6 addr" : "R7 addr"),
                        wr_addr, exp_addr[m_widx]);
                    chk(m_widx == 0 ? "R4 data" : (m_widx == 1 ? "R6 data" : "R7 data"),
                        wr_data, exp_data[m_widx]);
                end
                chk("R9 busy", busy, (m_state >= 1 && m_state <= 4));
                chk("R8 done", done, (m_state == 5));
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (m_state != 5) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);            // R1 idle state
        ready_mode = 0;
        pulse_start();                        // R2..R7 with ready always high
        wait_done();                          // R8 done held
        ready_mode = 1;
        pulse_start();                        // restart from done
        repeat (7) @(negedge clk);
        pulse_start();                        // R9 start during settle
        while (m_state != 2) @(negedge clk);
        pulse_start();                        // R9 start during reset hold
        while (m_state != 3) @(negedge clk);
        pulse_start();                        // R9 start during writes
        wait_done();
        pulse_start();
        repeat (20) @(negedge clk);
        rst = 1'b1;                           // R10 reset mid-sequence
        mid_reset = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        mid_reset = 0;
        ready_mode = 2;                       // R5 long stalls on every write
        pulse_start();
        wait_done();
        ready_mode = 0;
        pulse_start();
        wait_done();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule